// File: doc/BRIEF.md
# Dual-Clock Serial Elastic Store

This block is a first-in, first-out buffer one bit wide. It absorbs the difference in rate between a serial producer and a serial consumer that run on separate clocks. The two clocks may be unrelated or may be the same net. Bits enter on the write clock through a valid/ready handshake. Each side keeps its own binary pointer and passes a Gray-coded copy to the other side through a chain of synchronizer flops. The chain is two stages deep toward the write side and three stages deep toward the read side.

The read side works in first-word-fall-through fashion. A holding register presents the oldest bit with `rd_valid` high, and that bit is no longer part of the storage count. The storage array holds `DEPTH` bits, so the block can buffer `DEPTH` stored bits plus the one held bit. Back-pressure works as follows:
- On the write side, a producer may hold `wr_valid` high for as long as it likes. A transfer happens only on a write-clock edge at which `wr_ready` is also high.
- On the read side, the consumer may raise or lower `rd_ready` freely. While `rd_valid` is high and `rd_ready` is low, `rd_data` stays where it is.

Two level flags are computed in the write-clock domain. `half_full` reports the storage level against half the depth. `almost_fe` is a single flag that warns of both an almost-empty and an almost-full condition. Both flags lag the true level by the synchronizer latency.

Top module: `serial_elastic_fifo`

## Requirements
- R1: A bit on `wr_data` is stored at a rising `wr_clk` edge when `wr_valid` and `wr_ready` are both high; when `wr_ready` is low, a write attempt is ignored and leaves the stored contents unchanged.
- R2: The held bit is consumed at a rising `rd_clk` edge when `rd_valid` and `rd_ready` are both high; `rd_ready` while `rd_valid` is low has no effect.
- R3: Bits leave in the order they were accepted, whether the two clocks are identical or unrelated.
- R4: Storage holds `DEPTH` bits. Once the count of stored bits, which excludes the held bit, settles, `wr_ready` is high exactly when that count is below `DEPTH`. With the read side stalled, `DEPTH`+1 writes are accepted in total.
- R5: Once settled, `half_full` is 1 exactly when the stored count is at least `DEPTH`/2.
- R6: Once settled, `almost_fe` is 1 exactly when the stored count is at most `ALMOST_TH` (8) or at least `DEPTH`-`ALMOST_TH`.
- R7: The oldest bit falls through into the holding register without a read request and is not counted as stored. While it waits with `rd_ready` low, `rd_valid` and `rd_data` stay stable.
- R8: While `rst_n` is low, `wr_ready`=1, `rd_valid`=0, `half_full`=0 and `almost_fe`=1, and both pointers are cleared.
- R9: With both clocks the same, a bit written into an empty buffer at edge E0 raises `rd_valid` just after edge E4: three stages of synchronizer, then the load of the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_valid | input | 1 | Producer offers a bit |
| wr_data | input | 1 | Bit offered by the producer |
| wr_ready | output | 1 | Space available (write domain) |
| rd_clk | input | 1 | Read clock |
| rd_ready | input | 1 | Consumer takes the held bit |
| rd_valid | output | 1 | Holding register is occupied (read domain) |
| rd_data | output | 1 | Held bit |
| half_full | output | 1 | Stored count at least half the depth |
| almost_fe | output | 1 | Stored count within the threshold of empty or of full |

## Verification
The bench walks the level up one bit at a time from empty to full. At each step it compares `wr_ready`, `half_full` and `almost_fe` against the level. This catches a design that counts the held bit: it would be off by one at every flag boundary and would accept `DEPTH` writes instead of `DEPTH`+1. It checks that writes offered at full and reads requested at empty are ignored; a design that moved a pointer there would later deliver a stale or duplicated bit. Exact fall-through latency is checked, which catches a read chain that is too short or is bypassed. A long stream with random handshakes on unrelated clocks catches reordering or loss in the pointer crossing.

// File: rtl/sef_pkg.sv
package sef_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(input ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sef_store.sv
module sef_store #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wbit;
  end

  assign rbit = cells[raddr];
endmodule

// File: rtl/sef_wr_ctrl.sv
module sef_wr_ctrl
  import sef_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ALMOST_TH = 8,
  parameter int SYNC_LEN  = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [PW-1:0] rgray_async,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic          half_full,
  output logic          almost_fe
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LOW_P   = PW'(ALMOST_TH);
  localparam logic [PW-1:0] HIGH_P  = PW'(DEPTH - ALMOST_TH);

  logic [PW-1:0] wptr, wptr_nxt, rsync_g, rsync_b, level_nxt, level_now;

  sef_sync #(.W(PW), .STAGES(SYNC_LEN)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .d_async(rgray_async), .q(rsync_g)
  );

  assign rsync_b   = PW'(from_gray(ptr_t'(rsync_g)));
  assign push      = wr_valid && wr_ready;
  assign wptr_nxt  = wptr + PW'(push);
  assign level_nxt = wptr_nxt - rsync_b;
  assign level_now = wptr - rsync_b;
  assign waddr     = wptr[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      wgray     <= '0;
      wr_ready  <= 1'b1;
      half_full <= 1'b0;
      almost_fe <= 1'b1;
    end else begin
      wptr      <= wptr_nxt;
      wgray     <= PW'(to_gray(ptr_t'(wptr_nxt)));
      wr_ready  <= level_nxt < DEPTH_P;
      half_full <= level_nxt >= HALF_P;
      almost_fe <= (level_nxt <= LOW_P) || (level_nxt >= HIGH_P);
    end
  end

  AST_WR_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    level_now <= DEPTH_P);                                             // R4
  AST_WR_IGNORED: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wgray));                       // R1
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);                            // R3
  AST_FULL_FLAGS: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_ready |-> (half_full && almost_fe));                           // R5
endmodule

// File: rtl/sef_rd_ctrl.sv
module sef_rd_ctrl
  import sef_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SYNC_LEN = 3,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_data,
  input  logic [PW-1:0] wgray_async,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  input  logic          mem_bit
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] rptr, rptr_nxt, wsync_g, wsync_b;
  logic          avail, take;

  sef_sync #(.W(PW), .STAGES(SYNC_LEN)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .d_async(wgray_async), .q(wsync_g)
  );

  assign wsync_b  = PW'(from_gray(ptr_t'(wsync_g)));
  assign avail    = wsync_b != rptr;
  assign take     = avail && (!rd_valid || rd_ready);
  assign rptr_nxt = rptr + PW'(take);
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rgray    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= PW'(to_gray(ptr_t'(rptr_nxt)));
      if (take) begin
        rd_valid <= 1'b1;
        rd_data  <= mem_bit;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  AST_RD_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (wsync_b - rptr) <= DEPTH_P);                                      // R2
  AST_HOLD_STABLE: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));       // R7
  AST_RD_IGNORED: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_valid && !avail) |=> $stable(rgray));                         // R2
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);                            // R3
endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo #(
  parameter int DEPTH      = 64,
  parameter int ALMOST_TH  = 8,
  parameter int WR_SYNC    = 2,
  parameter int RD_SYNC    = 3,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic wr_clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_data,
  output logic wr_ready,
  input  logic rd_clk,
  input  logic rd_ready,
  output logic rd_valid,
  output logic rd_data,
  output logic half_full,
  output logic almost_fe
);
  logic [PW-1:0] wgray, rgray;
  logic [AW-1:0] waddr, raddr;
  logic          push, mem_bit;

  sef_wr_ctrl #(.DEPTH(DEPTH), .ALMOST_TH(ALMOST_TH), .SYNC_LEN(WR_SYNC)) u_wr (
    .wclk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rgray_async(rgray), .wgray(wgray), .waddr(waddr), .push(push),
    .half_full(half_full), .almost_fe(almost_fe)
  );

  sef_store #(.DEPTH(DEPTH)) u_store (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wbit(wr_data),
    .raddr(raddr), .rbit(mem_bit)
  );

  sef_rd_ctrl #(.DEPTH(DEPTH), .SYNC_LEN(RD_SYNC)) u_rd (
    .rclk(rd_clk), .rst_n(rst_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .wgray_async(wgray), .rgray(rgray), .raddr(raddr),
    .mem_bit(mem_bit)
  );
endmodule

// File: tb/test_serial_elastic_fifo.sv
module test_serial_elastic_fifo;
  localparam int DEPTH = 64;
  localparam int TH    = 8;

  logic wr_clk = 1'b0, rclk_a = 1'b0, async_mode = 1'b0;
  logic rst_n = 1'b0, wr_valid = 1'b0, wr_data = 1'b0, rd_ready = 1'b0;
  logic rd_clk, wr_ready, rd_valid, rd_data, half_full, almost_fe;
  int   n_chk = 0, n_fail = 0;
  bit   exp_q[$];

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rclk_a = ~rclk_a;
  assign rd_clk = async_mode ? rclk_a : wr_clk;

  serial_elastic_fifo #(.DEPTH(DEPTH), .ALMOST_TH(TH)) i_serial_elastic_fifo (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .half_full(half_full),
    .almost_fe(almost_fe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge wr_clk);
    chk("R8 wr_ready", wr_ready, 1);
    chk("R8 rd_valid", rd_valid, 0);
    chk("R8 half_full", half_full, 0);
    chk("R8 almost_fe", almost_fe, 1);
    rst_n = 1'b1;
  endtask

  task automatic drain(input int n, input string req);
    int got = 0;
    for (int i = 0; i < 20 * n + 40 && got < n; i++) begin
      @(negedge rd_clk);
      if (rd_valid) begin
        bit e = exp_q.pop_front();
        chk(req, rd_data, e);
        got++;
      end
      rd_ready = 1'b1;
    end
    @(negedge rd_clk);
    rd_ready = 1'b0;
    chk({req, " count"}, got, n);
  endtask

  task automatic t_latency();
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = 1'b1;
    exp_q.push_back(1'b1);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge wr_clk);
      chk($sformatf("R9 rd_valid after E%0d", k), rd_valid, k == 4);
    end
    drain(1, "R7 fall-through bit");
  endtask

  task automatic t_empty_ignore();
    rd_ready = 1'b1;
    repeat (12) begin
      @(negedge rd_clk);
      if (rd_valid) chk("R2 rd_valid at empty", rd_valid, 0);
    end
    rd_ready = 1'b0;
    chk("R2 rd_valid stays low", rd_valid, 0);
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = 1'b0;
    exp_q.push_back(1'b0);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    drain(1, "R2 no pointer moved");
  endtask

  task automatic t_fill_flags();
    int acc = 0;
    int st;
    for (int n = 0; n < DEPTH + 4; n++) begin
      bit d = 1'($urandom);
      @(negedge wr_clk);
      wr_valid = 1'b1; wr_data = d;
      if (wr_ready) begin exp_q.push_back(d); acc++; end
      @(negedge wr_clk);
      wr_valid = 1'b0;
      repeat (10) @(negedge wr_clk);
      st = acc - 1;
      chk($sformatf("R4 wr_ready at %0d", st), wr_ready, st < DEPTH);
      chk($sformatf("R5 half_full at %0d", st), half_full, st >= DEPTH / 2);
      chk($sformatf("R6 almost_fe at %0d", st), almost_fe,
          (st <= TH) || (st >= DEPTH - TH));
      chk("R7 held bit valid", rd_valid, 1);
      chk("R7 held bit value", rd_data, exp_q[0]);
    end
    chk("R1 accepted total", acc, DEPTH + 1);
    drain(DEPTH + 1, "R3 order after fill");
    repeat (10) @(negedge wr_clk);
    chk("R4 ready after drain", wr_ready, 1);
    chk("R6 almost after drain", almost_fe, 1);
    chk("R5 half after drain", half_full, 0);
  endtask

  task automatic t_async_stream();
    int sent = 0, got = 0, bad = 0;
    async_mode = 1'b1;
    repeat (4) @(negedge wr_clk);
    fork
      begin
        while (sent < 300) begin
          @(negedge wr_clk);
          wr_valid = 1'($urandom);
          wr_data  = 1'($urandom);
          if (wr_valid && wr_ready) begin exp_q.push_back(wr_data); sent++; end
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
      end
      begin
        for (int i = 0; i < 5000 && got < 300; i++) begin
          bit r = 1'($urandom);
          @(negedge rd_clk);
          if (r && rd_valid) begin
            bit e = exp_q.pop_front();
            if (rd_data != e) bad++;
            got++;
          end
          rd_ready = r;
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
      end
    join
    chk("R3 async bits received", got, 300);
    chk("R3 async mismatches", bad, 0);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_empty_ignore();
    t_fill_flags();
    t_async_stream();
    finish_run();
  end
endmodule